// File: doc/BRIEF.md
# Masked Event Combiner Register Bank

This block collects up to 128 single-cycle system event pulses into sticky flag bits. The flags are arranged as four groups of 32, and event number n lives in group n/32 at bit n%32. Software reaches the bank through a simple 32-bit register port. Through that port it can set flags, clear them with write-one-to-clear semantics, and program two independent masks per group. The event mask feeds the combined outputs, and the exception mask feeds a second masked view used for exception handling.

Each group drives one combined output. That output is high while any flag of the group is set and not blocked by its event mask, where a mask bit of 1 blocks. Event numbers 0 to 3 are reserved for these combined outputs. A change of level on combined output g is fed back and latched as event g, which sits in group 0. The bank also has an event-assert register. A write to it emits a one-cycle pulse that carries the written value out of the block.

Top module: `evc_bank`

## Requirements
- R1: A pulse on `evt_in[n]`, for n of 4 or more, sets flag bit n%32 of group n/32 at the next clock edge. A set flag stays set until software clears it.
- R2: Writing to the set register of group g (byte address 0x20+4g) sets every flag bit written as 1. Bits written as 0 leave their flags unchanged.
- R3: Writing to the clear register of group g (byte address 0x40+4g) clears every flag bit written as 1. Bits written as 0 have no effect. When a hardware event hits a bit in the same cycle that a clear hits it, the flag ends up set.
- R4: The event mask of group g sits at 0x80+4g and is read/write; a mask bit of 1 blocks its event. The masked flag register at 0xA0+4g reads flag AND NOT event mask.
- R5: The exception mask of group g sits at 0xC0+4g and is read/write. The masked exception flag register at 0xE0+4g reads flag AND NOT exception mask. The two masks are independent of each other.
- R6: `comb_out[g]` is the OR of group g's masked flags. It changes in the same cycle as the flags and mask it depends on.
- R7: Whenever `comb_out[g]` changes level, flag bit g of group 0 is set at the following edge. `evt_in[3:0]` has no effect on the flags.
- R8: After reset, all flags are 0, both masks of every group are all ones, `comb_out` is 0 and `asrt_pulse` is 0.
- R9: A write to byte address 0x1C0 drives `asrt_pulse` high for exactly the one cycle after the write edge. During that cycle `asrt_value` equals the written data.
- R10: A read returns its data on `bus_rdata` after the next clock edge. The flag register of group g is at 0x00+4g. The set, clear and assert registers, group indices of 4 or more, and unaligned or unused addresses all read as 0. Writes to the flag and masked-flag registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 128 | Single-cycle event pulses, one per event number |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| comb_out | output | 4 | Combined event output per group |
| asrt_pulse | output | 1 | One-cycle pulse after an event-assert write |
| asrt_value | output | 32 | Value written to the event-assert register |

## Verification
The bench builds the bank with its defaults of four groups of 32 events. At that size the feedback bits 0 to 3 of group 0 interact with ordinary events in groups 1 to 3, and the unused group indices 4 to 7 of the address map can be probed for reads of zero. Random mask contents, sparse events and mixed set and clear writes keep the combined outputs toggling. This exercises the level-change feedback into group 0, while directed cases pin down the clear-versus-event race and the independence of the two masks.

// File: rtl/evc_pkg.sv
package evc_pkg;
    // byte address width of the register port
    localparam int ADDR_W = 9;
    // register bank codes, taken from address bits [8:5]
    localparam logic [3:0] BK_FLAG  = 4'h0;
    localparam logic [3:0] BK_SET   = 4'h1;
    localparam logic [3:0] BK_CLR   = 4'h2;
    localparam logic [3:0] BK_MASK  = 4'h4;
    localparam logic [3:0] BK_MFLAG = 4'h5;
    localparam logic [3:0] BK_XMASK = 4'h6;
    localparam logic [3:0] BK_XFLAG = 4'h7;
    localparam logic [3:0] BK_ASRT  = 4'hE;
    localparam logic [ADDR_W-1:0] ASRT_ADDR = 9'h1C0;
endpackage

// File: rtl/evc_decode.sv
module evc_decode
    import evc_pkg::*;
#(
    parameter int NG = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NG-1:0]     set_we,
    output logic [NG-1:0]     clr_we,
    output logic [NG-1:0]     mask_we,
    output logic [NG-1:0]     xmask_we,
    output logic              asrt_we,
    output logic [3:0]        bank,
    output logic [2:0]        grp,
    output logic              grp_ok
);
    always_comb begin
        bank     = addr[8:5];
        grp      = addr[4:2];
        grp_ok   = (int'(addr[4:2]) < NG) && (addr[1:0] == 2'b00);
        asrt_we  = wr_en && (addr == ASRT_ADDR);
        set_we   = '0;
        clr_we   = '0;
        mask_we  = '0;
        xmask_we = '0;
        for (int g = 0; g < NG; g++) begin
            if (wr_en && grp_ok && (grp == 3'(g))) begin
                set_we[g]   = (bank == BK_SET);
                clr_we[g]   = (bank == BK_CLR);
                mask_we[g]  = (bank == BK_MASK);
                xmask_we[g] = (bank == BK_XMASK);
            end
        end
    end
endmodule

// File: rtl/evc_group.sv
module evc_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_evt,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic         xmask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag,
    output logic [W-1:0] mask,
    output logic [W-1:0] xmask,
    output logic [W-1:0] mflag,
    output logic [W-1:0] xflag,
    output logic         comb
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] mask;
        logic [W-1:0] xmask;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.flag = st_q.flag & ~wdata;
        end
        // hardware events land after the clear, so they win a race
        st_d.flag = st_d.flag | hw_evt;
        if (set_we) begin
            st_d.flag = st_d.flag | wdata;
        end
        if (mask_we) begin
            st_d.mask = wdata;
        end
        if (xmask_we) begin
            st_d.xmask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag  <= '0;
            st_q.mask  <= '1;
            st_q.xmask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign mask  = st_q.mask;
    assign xmask = st_q.xmask;
    assign mflag = st_q.flag & ~st_q.mask;
    assign xflag = st_q.flag & ~st_q.xmask;
    assign comb  = |mflag;
endmodule

// File: rtl/evc_bank.sv
module evc_bank
    import evc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] evt_in,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [GROUP_W-1:0]            bus_wdata,
    output logic [GROUP_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]         comb_out,
    output logic                          asrt_pulse,
    output logic [GROUP_W-1:0]            asrt_value
);
    localparam int NG      = NUM_GROUPS;
    localparam int W       = GROUP_W;
    localparam int NUM_EVT = NG * W;

    typedef struct packed {
        logic [NG-1:0] prev;
        logic [W-1:0]  rdata;
        logic          pulse;
        logic [W-1:0]  aval;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NG-1:0]        set_we, clr_we, mask_we, xmask_we;
    logic                 asrt_we;
    logic [3:0]           bank;
    logic [2:0]           grp;
    logic                 grp_ok;
    logic [NUM_EVT-1:0]   hw_evt;
    logic [NG-1:0][W-1:0] flag_a, mask_a, xmask_a, mflag_a, xflag_a;
    logic [W-1:0]         rd_word;
    // observation taps for the bound checker
    logic [NG-1:0]        top_flag;
    logic [NG-1:0]        top_evt;
    logic [NG-1:0]        fb_flag;

    evc_decode #(.NG(NG)) u_dec (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .mask_we  (mask_we),
        .xmask_we (xmask_we),
        .asrt_we  (asrt_we),
        .bank     (bank),
        .grp      (grp),
        .grp_ok   (grp_ok)
    );

    always_comb begin
        hw_evt = evt_in;
        // low event numbers are owned by the combiner feedback
        hw_evt[NG-1:0] = comb_out ^ st_q.prev;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        evc_group #(.W(W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_evt   (hw_evt[g*W +: W]),
            .set_we   (set_we[g]),
            .clr_we   (clr_we[g]),
            .mask_we  (mask_we[g]),
            .xmask_we (xmask_we[g]),
            .wdata    (bus_wdata),
            .flag     (flag_a[g]),
            .mask     (mask_a[g]),
            .xmask    (xmask_a[g]),
            .mflag    (mflag_a[g]),
            .xflag    (xflag_a[g]),
            .comb     (comb_out[g])
        );
        assign top_flag[g] = flag_a[g][W-1];
        assign top_evt[g]  = evt_in[g*W + W-1];
        assign fb_flag[g]  = flag_a[0][g];
    end

    always_comb begin
        rd_word = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp_ok && (grp == 3'(g))) begin
                case (bank)
                    BK_FLAG:  rd_word = flag_a[g];
                    BK_MASK:  rd_word = mask_a[g];
                    BK_MFLAG: rd_word = mflag_a[g];
                    BK_XMASK: rd_word = xmask_a[g];
                    BK_XFLAG: rd_word = xflag_a[g];
                    default:  rd_word = '0;
                endcase
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = comb_out;
        st_d.pulse = asrt_we;
        if (bus_rd) begin
            st_d.rdata = rd_word;
        end
        if (asrt_we) begin
            st_d.aval = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign asrt_pulse = st_q.pulse;
    assign asrt_value = st_q.aval;
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
    import evc_pkg::*;
#(
    parameter int NG = 4,
    parameter int W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [NG-1:0]     comb_out,
    input logic              asrt_pulse,
    input logic [W-1:0]      asrt_value,
    input logic [NG-1:0]     top_flag,
    input logic [NG-1:0]     top_evt,
    input logic [NG-1:0]     fb_flag
);
    for (genvar g = 0; g < NG; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(32'h40 + 4 * g);

        assert_evt_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
            top_evt[g] |=> top_flag[g]);

        assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
            top_flag[g] && !(bus_wr && bus_addr == CLR_A) |=> top_flag[g]);

        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == CLR_A && bus_wdata[W-1] && !top_evt[g] |=> !top_flag[g]);

        assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == CLR_A && top_evt[g] |=> top_flag[g]);

        assert_feedback_R7: assert property (@(posedge clk) disable iff (!rst_n)
            comb_out[g] != $past(comb_out[g]) |=> fb_flag[g]);
    end

    assert_pulse_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ASRT_ADDR |=> asrt_pulse && asrt_value == $past(bus_wdata));

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        asrt_pulse |-> $past(bus_wr && bus_addr == ASRT_ADDR));
endmodule

bind evc_bank evc_bank_chk #(.NG(NUM_GROUPS), .W(GROUP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .comb_out   (comb_out),
    .asrt_pulse (asrt_pulse),
    .asrt_value (asrt_value),
    .top_flag   (top_flag),
    .top_evt    (top_evt),
    .fb_flag    (fb_flag)
);

// File: tb/evc_bank_test.sv
`timescale 1ns/1ps
module evc_bank_test;
    localparam int NG = 4;
    localparam int W  = 32;
    localparam int NE = NG * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NE-1:0] evt_in;
    logic          bus_wr, bus_rd;
    logic [8:0]    bus_addr;
    logic [W-1:0]  bus_wdata, bus_rdata, asrt_value;
    logic [NG-1:0] comb_out;
    logic          asrt_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    logic [W-1:0]  m_flag [NG];
    logic [W-1:0]  m_mask [NG];
    logic [W-1:0]  m_xmask[NG];
    logic [NG-1:0] m_prev;

    always #2 clk = ~clk;

    evc_bank #(.NUM_GROUPS(NG), .GROUP_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .comb_out(comb_out), .asrt_pulse(asrt_pulse), .asrt_value(asrt_value)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NG-1:0] model_comb();
        logic [NG-1:0] c;
        for (int g = 0; g < NG; g++) c[g] = |(m_flag[g] & ~m_mask[g]);
        return c;
    endfunction

    function automatic logic [W-1:0] model_read(input logic [8:0] a);
        int g = int'(a[4:2]);
        if (a[1:0] != 2'b00 || g >= NG) return '0;
        case (a[8:5])
            4'h0: return m_flag[g];
            4'h4: return m_mask[g];
            4'h5: return m_flag[g] & ~m_mask[g];
            4'h6: return m_xmask[g];
            4'h7: return m_flag[g] & ~m_xmask[g];
            default: return '0;
        endcase
    endfunction

    // one bus/event cycle, then checks half a cycle after the edge
    task automatic op(input logic [NE-1:0] evt, input logic wr, input logic rd,
                      input logic [8:0] a, input logic [W-1:0] wd, input string tag);
        logic [W-1:0]  exp_rd = model_read(a);
        logic [NG-1:0] c      = model_comb();
        logic [NE-1:0] hw     = evt;
        logic [W-1:0]  nf[NG], nm[NG], nx[NG];
        hw[NG-1:0] = c ^ m_prev;
        for (int g = 0; g < NG; g++) begin
            nf[g] = m_flag[g];
            nm[g] = m_mask[g];
            nx[g] = m_xmask[g];
            if (wr && a == 9'(32'h40 + 4 * g)) nf[g] = nf[g] & ~wd;
            nf[g] = nf[g] | hw[g*W +: W];
            if (wr && a == 9'(32'h20 + 4 * g)) nf[g] = nf[g] | wd;
            if (wr && a == 9'(32'h80 + 4 * g)) nm[g] = wd;
            if (wr && a == 9'(32'hC0 + 4 * g)) nx[g] = wd;
        end
        evt_in = evt; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        #1;
        for (int g = 0; g < NG; g++) begin
            m_flag[g] = nf[g]; m_mask[g] = nm[g]; m_xmask[g] = nx[g];
        end
        m_prev = c;
        evt_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        chk(comb_out == model_comb(), "R6 comb_out", W'(comb_out), W'(model_comb()));
        if (rd) chk(bus_rdata == exp_rd, {tag, " read"}, bus_rdata, exp_rd);
        if (wr && a == 9'h1C0) begin
            chk(asrt_pulse === 1'b1, "R9 pulse high", W'(asrt_pulse), 1);
            chk(asrt_value == wd, "R9 pulse value", asrt_value, wd);
        end else begin
            chk(asrt_pulse === 1'b0, "R9 pulse low", W'(asrt_pulse), 0);
        end
    endtask

    task automatic rd(input logic [8:0] a, input string tag);
        op('0, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic wr(input logic [8:0] a, input logic [W-1:0] d, input string tag);
        op('0, 1'b1, 1'b0, a, d, tag);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; evt_in = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int g = 0; g < NG; g++) begin
            m_flag[g] = '0; m_mask[g] = '1; m_xmask[g] = '1;
        end
        m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(comb_out == '0, "R8 comb_out reset", W'(comb_out), 0);
        chk(asrt_pulse == 1'b0, "R8 pulse reset", W'(asrt_pulse), 0);
        rd(9'h080, "R8 mask reset");
        rd(9'h0CC, "R8 xmask reset");
        rd(9'h000, "R8 flag reset");
        // R1 capture while masked
        op(NE'(1) << 40, 1'b0, 1'b0, 9'h000, '0, "R1");
        rd(9'h004, "R1 flag g1");
        // R4 unmask, combined goes high, R7 feedback into group 0
        wr(9'h084, ~32'h100, "R4 mask write");
        rd(9'h0A4, "R4 masked flag");
        rd(9'h000, "R7 feedback flag");
        // R7 low event inputs ignored
        wr(9'h040, 32'hFFFF_FFFF, "R7 clear g0");
        op(NE'(4'hF), 1'b0, 1'b0, 9'h000, '0, "R7");
        rd(9'h000, "R7 low events ignored");
        // R2 set register
        wr(9'h028, 32'h0000_00A5, "R2 set");
        rd(9'h008, "R2 set result");
        // R3 clear racing a hardware event on bit 0 of group 2
        op(NE'(1) << 64, 1'b1, 1'b0, 9'h048, 32'h0000_00FF, "R3");
        rd(9'h008, "R3 event wins");
        // R5 independent exception mask
        wr(9'h0C8, 32'hFFFF_FFFE, "R5 xmask write");
        rd(9'h0E8, "R5 masked exception flag");
        rd(9'h0A8, "R5 event view unaffected");
        // R9 event assert
        wr(9'h1C0, 32'hDEAD_BEEF, "R9");
        rd(9'h1C0, "R10 assert reads zero");
        // R10 read-only and unused addresses
        wr(9'h000, 32'hFFFF_FFFF, "R10 flag write");
        wr(9'h0A4, 32'hFFFF_FFFF, "R10 mflag write");
        rd(9'h000, "R10 flag unchanged");
        rd(9'h004, "R10 flag g1 unchanged");
        rd(9'h020, "R10 set reads zero");
        rd(9'h014, "R10 group 5 reads zero");
        rd(9'h002, "R10 unaligned reads zero");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [NE-1:0] ev;
            logic [3:0]    bk;
            logic [8:0]    a;
            int            sel = int'($urandom_range(0, 8));
            for (int k = 0; k < NG; k++)
                ev[k*W +: W] = $urandom() & $urandom() & $urandom() & $urandom();
            case (sel)
                0: bk = 4'h0; 1: bk = 4'h1; 2: bk = 4'h2; 3: bk = 4'h4;
                4: bk = 4'h5; 5: bk = 4'h6; 6: bk = 4'h7; 7: bk = 4'hE;
                default: bk = 4'h3;
            endcase
            a = {bk, 3'($urandom_range(0, 4)), 2'b00};
            if (bk == 4'hE) a = 9'h1C0;
            op(($urandom_range(0, 3) == 0) ? ev : '0, $urandom_range(0, 2) == 0,
               $urandom_range(0, 1) == 1, a, $urandom(), "R10 random");
        end
        summary();
        $finish;
    end
endmodule